// File: doc/BRIEF.md
# Interleaved Flash Array Access Controller

This block sits between a 32-bit big-endian request/ready bus and a flash storage model made of four physical blocks. Each physical block holds two 16-bit half-arrays. The high array holds the upper half of each logical longword and the low array holds the lower half. Consecutive aligned longwords alternate between the two blocks of a pair, and one address bit above the word index picks the pair. The storage is a set of synthesizable register arrays. The array depth and the erase-page size are parameters, so a reduced model can stand in for the full one.

Reads of a byte, an aligned 16-bit word or an aligned longword return after a fixed two-cycle latency. Data comes back in its big-endian byte lanes. Writes are commands. A single aligned 32-bit write carries a two-bit command code, which selects program, page erase or mass erase. After an accepted command the block reports busy for a fixed number of cycles. During that window every request is refused with a transfer error. A malformed write is also refused with an error and leaves the storage untouched.

Top module: `ilv_flash_ctrl`

## Requirements
- R1: After reset `rdy`, `err` and `busy` are low, and every location reads back 32'hFFFFFFFF (erased).
- R2: Address decode for a request: bit 2 selects the block within a pair, bits [WORD_AW+2:3] form the word index, and bit WORD_AW+3 selects the pair. The longwords at byte addresses 4n and 4n+4 therefore lie in different blocks of the same pair.
- R3: A read sampled with `req` high at clock edge k raises `rdy` with valid `rdata` and `err` low after edge k+2.
- R4: Size codes are 0 for a byte, 1 for a word and 2 for a longword. A longword reads as {high array, low array}. Byte address offset 0 maps to `rdata[31:24]`, offset 1 to `[23:16]`, offset 2 to `[15:8]` and offset 3 to `[7:0]`. A word at offset 0 appears on `[31:16]` and a word at offset 2 on `[15:0]`. Lanes that were not read are zero.
- R5: A read with size code 3, a word read at an odd address, or a longword read whose addr[1:0] is not 0 gets `rdy` and `err` one cycle after it is sampled, with `rdata` zero.
- R6: A write whose size code is not 2, or whose addr[1:0] is not 0, gets `rdy` and `err` one cycle after it is sampled and changes no stored data.
- R7: Command code 0 programs one longword. The stored value becomes the old value ANDed with `wdata`, and `rdy` rises with `err` low one cycle after the request is sampled.
- R8: Command code 1 sets to all ones the 2**PAGE_AW word indices that share the addressed index's upper bits. It does so in both blocks of the addressed pair and leaves other pages and the other pair unchanged.
- R9: Command code 2 sets every location of both blocks of the addressed pair to all ones and leaves the other pair unchanged.
- R10: After an accepted command, `busy` stays high for exactly BUSY_CYC cycles. Any request sampled while `busy` is high gets an error and changes nothing. Command code 3 is always refused with an error.
- R11: `err` is never high without `rdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, one cycle per transfer |
| we | input | 1 | 1 = command write, 0 = read |
| size | input | 2 | Transfer size: 0 byte, 1 word, 2 longword |
| op | input | 2 | Command code for writes: 0 program, 1 page erase, 2 mass erase |
| addr | input | WORD_AW+4 | Byte address |
| wdata | input | 32 | Program data |
| rdy | output | 1 | Response strobe |
| err | output | 1 | Transfer error, valid with rdy |
| rdata | output | 32 | Read data in big-endian lanes, zero outside a good read |
| busy | output | 1 | Command execution window |

## Verification
The bench builds the block with WORD_AW=6, PAGE_AW=4 and BUSY_CYC=5. With these values there are 64 words per half-array and four erase pages per pair. The last index of pair 1 sits at byte address 0x3FC, so it can be programmed and then cleared by mass erase. An index in the second page stays intact through a page erase of the first page. The short busy window lets the bench count it cycle by cycle and place rejected requests inside it.

// File: rtl/ilv_flash_pkg.sv
package ilv_flash_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    CMD_PROG = 2'd0,
    CMD_PAGE = 2'd1,
    CMD_MASS = 2'd2,
    CMD_RSVD = 2'd3
  } cmd_code_e;

  // read alignment rule for a given size and low address bits
  function automatic logic rd_aligned(input xfer_size_e sz, input logic [1:0] lo);
    case (sz)
      SZ_BYTE: rd_aligned = 1'b1;
      SZ_WORD: rd_aligned = ~lo[0];
      SZ_LONG: rd_aligned = (lo == 2'b00);
      default: rd_aligned = 1'b0;
    endcase
  endfunction

  // big-endian lane mask: offset 0 is the most significant byte
  function automatic logic [31:0] lane_mask(input xfer_size_e sz, input logic [1:0] lo);
    case (sz)
      SZ_BYTE: lane_mask = 32'hFF00_0000 >> {lo, 3'b000};
      SZ_WORD: lane_mask = lo[1] ? 32'h0000_FFFF : 32'hFFFF_0000;
      SZ_LONG: lane_mask = 32'hFFFF_FFFF;
      default: lane_mask = 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/ilv_flash_bank.sv
module ilv_flash_bank #(
  parameter int WORD_AW = 6,
  parameter int PAGE_AW = 4,
  localparam int DEPTH = 1 << WORD_AW,
  localparam int PG_W  = WORD_AW - PAGE_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WORD_AW-1:0] rd_idx,
  output logic [31:0]        rd_word,
  input  logic               prog_en,
  input  logic [WORD_AW-1:0] prog_idx,
  input  logic [31:0]        prog_data,
  input  logic               page_en,
  input  logic [PG_W-1:0]    page_num,
  input  logic               mass_en
);

  logic [15:0] hi_mem [DEPTH];
  logic [15:0] lo_mem [DEPTH];

  // high array feeds the upper half of the longword
  assign rd_word = {hi_mem[rd_idx], lo_mem[rd_idx]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        hi_mem[i] <= '1;
        lo_mem[i] <= '1;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (mass_en || (page_en && ((i >> PAGE_AW) == int'(page_num)))) begin
          hi_mem[i] <= '1;
          lo_mem[i] <= '1;
        end
      end
      if (prog_en) begin
        hi_mem[prog_idx] <= hi_mem[prog_idx] & prog_data[31:16];
        lo_mem[prog_idx] <= lo_mem[prog_idx] & prog_data[15:0];
      end
    end
  end

endmodule

// File: rtl/ilv_flash_ctrl_fsm.sv
module ilv_flash_ctrl_fsm
  import ilv_flash_pkg::*;
#(
  parameter int BUSY_CYC = 16,
  localparam int CNT_W = $clog2(BUSY_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       we,
  input  logic [1:0] size,
  input  logic [1:0] op,
  input  logic [1:0] addr_lo,
  output logic       rd_go,
  output logic       cmd_go,
  output logic       bad_go,
  output logic       rd_pend,
  output logic       rdy,
  output logic       err,
  output logic       busy
);

  logic [CNT_W-1:0] busy_cnt;
  logic             accept;
  logic             wr_bad;
  logic             rd_bad;
  logic             err_q;
  logic             wok_q;
  logic             rd_done_q;

  assign busy   = (busy_cnt != '0);
  assign accept = req && !rd_pend;
  assign wr_bad = (xfer_size_e'(size) != SZ_LONG) || (addr_lo != 2'b00)
                  || (cmd_code_e'(op) == CMD_RSVD);
  assign rd_bad = !rd_aligned(xfer_size_e'(size), addr_lo);
  assign bad_go = accept && (busy || (we ? wr_bad : rd_bad));
  assign rd_go  = accept && !we && !bad_go;
  assign cmd_go = accept && we && !bad_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt  <= '0;
      err_q     <= 1'b0;
      wok_q     <= 1'b0;
      rd_pend   <= 1'b0;
      rd_done_q <= 1'b0;
    end else begin
      err_q     <= bad_go;
      wok_q     <= cmd_go;
      rd_pend   <= rd_go;
      rd_done_q <= rd_pend;
      if (cmd_go)
        busy_cnt <= CNT_W'(BUSY_CYC);
      else if (busy)
        busy_cnt <= busy_cnt - 1'b1;
    end
  end

  assign rdy = err_q | wok_q | rd_done_q;
  assign err = err_q;

endmodule

// File: rtl/ilv_flash_ctrl.sv
module ilv_flash_ctrl
  import ilv_flash_pkg::*;
#(
  parameter int WORD_AW  = 6,
  parameter int PAGE_AW  = 4,
  parameter int BUSY_CYC = 16,
  localparam int ADDR_W  = WORD_AW + 4,
  localparam int PG_W    = WORD_AW - PAGE_AW,
  localparam int N_BLK   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic              rdy,
  output logic              err,
  output logic [31:0]       rdata,
  output logic              busy
);

  // address fields: bit 2 block in pair, word index above it, pair on top
  logic               a_blk;
  logic               a_pair;
  logic [WORD_AW-1:0] a_idx;
  logic [PG_W-1:0]    a_page;

  assign a_blk  = addr[2];
  assign a_idx  = addr[WORD_AW+2:3];
  assign a_pair = addr[WORD_AW+3];
  assign a_page = a_idx[WORD_AW-1:PAGE_AW];

  logic rd_go, cmd_go, bad_go, rd_pend;

  ilv_flash_ctrl_fsm #(.BUSY_CYC(BUSY_CYC)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .we      (we),
    .size    (size),
    .op      (op),
    .addr_lo (addr[1:0]),
    .rd_go   (rd_go),
    .cmd_go  (cmd_go),
    .bad_go  (bad_go),
    .rd_pend (rd_pend),
    .rdy     (rdy),
    .err     (err),
    .busy    (busy)
  );

  logic prog_go, page_go, mass_go;
  assign prog_go = cmd_go && (cmd_code_e'(op) == CMD_PROG);
  assign page_go = cmd_go && (cmd_code_e'(op) == CMD_PAGE);
  assign mass_go = cmd_go && (cmd_code_e'(op) == CMD_MASS);

  // read stage 1: hold decoded address while the array is read
  logic [1:0]         s1_blk;
  logic [WORD_AW-1:0] s1_idx;
  xfer_size_e         s1_size;
  logic [1:0]         s1_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_blk  <= '0;
      s1_idx  <= '0;
      s1_size <= SZ_BYTE;
      s1_lo   <= '0;
    end else if (rd_go) begin
      s1_blk  <= {a_pair, a_blk};
      s1_idx  <= a_idx;
      s1_size <= xfer_size_e'(size);
      s1_lo   <= addr[1:0];
    end
  end

  logic [31:0] bank_rd [N_BLK];

  for (genvar b = 0; b < N_BLK; b++) begin : g_blk
    localparam logic PAIR_ID = 1'(b >> 1);
    localparam logic SIDE_ID = 1'(b & 1);
    ilv_flash_bank #(.WORD_AW(WORD_AW), .PAGE_AW(PAGE_AW)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (s1_idx),
      .rd_word   (bank_rd[b]),
      .prog_en   (prog_go && (a_pair == PAIR_ID) && (a_blk == SIDE_ID)),
      .prog_idx  (a_idx),
      .prog_data (wdata),
      .page_en   (page_go && (a_pair == PAIR_ID)),
      .page_num  (a_page),
      .mass_en   (mass_go && (a_pair == PAIR_ID))
    );
  end

  // read stage 2: lane select into the output register
  logic [31:0] rdata_q;
  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata_q <= '0;
    else if (rd_pend)
      rdata_q <= bank_rd[s1_blk] & lane_mask(s1_size, s1_lo);
    else
      rdata_q <= '0;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/ilv_flash_chk.sv
module ilv_flash_chk (
  input logic clk,
  input logic rst_n,
  input logic req,
  input logic rdy,
  input logic err,
  input logic busy,
  input logic rd_go,
  input logic cmd_go,
  input logic bad_go
);

  p_rd_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |-> ##2 (rdy && !err));

  p_bad_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_go |=> (rdy && err));

  p_cmd_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> (rdy && !err && busy));

  p_busy_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && busy) |=> (rdy && err));

  p_err_rdy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> rdy);

  p_one_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_go, cmd_go, bad_go}));

endmodule

bind ilv_flash_ctrl ilv_flash_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .req    (req),
  .rdy    (rdy),
  .err    (err),
  .busy   (busy),
  .rd_go  (rd_go),
  .cmd_go (cmd_go),
  .bad_go (bad_go)
);

// File: tb/sim_ilv_flash_ctrl.sv
`timescale 1ns/1ps
module sim_ilv_flash_ctrl;

  localparam int WORD_AW  = 6;
  localparam int PAGE_AW  = 4;
  localparam int BUSY_CYC = 5;
  localparam int AW       = WORD_AW + 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [1:0]    size = 2'd0;
  logic [1:0]    op = 2'd0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic          rdy, err, busy;
  logic [31:0]   rdata;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ilv_flash_ctrl #(.WORD_AW(WORD_AW), .PAGE_AW(PAGE_AW), .BUSY_CYC(BUSY_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .size(size), .op(op),
    .addr(addr), .wdata(wdata), .rdy(rdy), .err(err), .rdata(rdata), .busy(busy)
  );

  typedef struct packed {
    logic          w;
    logic [1:0]    sz;
    logic [1:0]    cm;
    logic [AW-1:0] ad;
    logic [31:0]   wd;
    logic          xerr;
    logic [31:0]   xd;
    logic [3:0]    rq;
  } vec_t;

  localparam int NV = 37;
  // sz: 0 byte, 1 word, 2 long; cm: 0 prog, 1 page, 2 mass, 3 reserved
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd2, 2'd0, 10'h000, 32'h0, 1'b0, 32'hFFFFFFFF, 4'd1},  // R1 erased
    '{1'b1, 2'd2, 2'd0, 10'h000, 32'h12345678, 1'b0, 32'h0, 4'd7},  // R7
    '{1'b1, 2'd2, 2'd0, 10'h004, 32'h9ABCDEF0, 1'b0, 32'h0, 4'd7},
    '{1'b0, 2'd2, 2'd0, 10'h000, 32'h0, 1'b0, 32'h12345678, 4'd2},  // R2
    '{1'b0, 2'd2, 2'd0, 10'h004, 32'h0, 1'b0, 32'h9ABCDEF0, 4'd2},  // R2 other block
    '{1'b1, 2'd2, 2'd0, 10'h008, 32'hA5A50F0F, 1'b0, 32'h0, 4'd7},
    '{1'b1, 2'd2, 2'd0, 10'h008, 32'h0F0FFFFF, 1'b0, 32'h0, 4'd7},
    '{1'b0, 2'd2, 2'd0, 10'h008, 32'h0, 1'b0, 32'h05050F0F, 4'd7},  // R7 AND
    '{1'b0, 2'd0, 2'd0, 10'h000, 32'h0, 1'b0, 32'h12000000, 4'd4},  // R4 bytes
    '{1'b0, 2'd0, 2'd0, 10'h001, 32'h0, 1'b0, 32'h00340000, 4'd4},
    '{1'b0, 2'd0, 2'd0, 10'h002, 32'h0, 1'b0, 32'h00005600, 4'd4},
    '{1'b0, 2'd0, 2'd0, 10'h003, 32'h0, 1'b0, 32'h00000078, 4'd4},
    '{1'b0, 2'd1, 2'd0, 10'h000, 32'h0, 1'b0, 32'h12340000, 4'd4},  // R4 words
    '{1'b0, 2'd1, 2'd0, 10'h002, 32'h0, 1'b0, 32'h00005678, 4'd4},
    '{1'b0, 2'd1, 2'd0, 10'h001, 32'h0, 1'b1, 32'h0, 4'd5},         // R5
    '{1'b0, 2'd2, 2'd0, 10'h002, 32'h0, 1'b1, 32'h0, 4'd5},
    '{1'b1, 2'd1, 2'd0, 10'h000, 32'h0, 1'b1, 32'h0, 4'd6},         // R6
    '{1'b1, 2'd2, 2'd0, 10'h001, 32'h0, 1'b1, 32'h0, 4'd6},
    '{1'b1, 2'd2, 2'd3, 10'h000, 32'h0, 1'b1, 32'h0, 4'd10},        // R10 code 3
    '{1'b0, 2'd2, 2'd0, 10'h000, 32'h0, 1'b0, 32'h12345678, 4'd6},  // R6 unchanged
    '{1'b1, 2'd2, 2'd0, 10'h200, 32'h11111111, 1'b0, 32'h0, 4'd2},
    '{1'b0, 2'd2, 2'd0, 10'h200, 32'h0, 1'b0, 32'h11111111, 4'd2},  // R2 pair bit
    '{1'b1, 2'd2, 2'd0, 10'h080, 32'h00000000, 1'b0, 32'h0, 4'd8},
    '{1'b1, 2'd2, 2'd0, 10'h3FC, 32'h00000000, 1'b0, 32'h0, 4'd9},
    '{1'b1, 2'd2, 2'd1, 10'h004, 32'h0, 1'b0, 32'h0, 4'd8},         // R8 page 0 pair 0
    '{1'b0, 2'd2, 2'd0, 10'h000, 32'h0, 1'b0, 32'hFFFFFFFF, 4'd8},
    '{1'b0, 2'd2, 2'd0, 10'h004, 32'h0, 1'b0, 32'hFFFFFFFF, 4'd8},
    '{1'b0, 2'd2, 2'd0, 10'h008, 32'h0, 1'b0, 32'hFFFFFFFF, 4'd8},
    '{1'b0, 2'd2, 2'd0, 10'h080, 32'h0, 1'b0, 32'h00000000, 4'd8},
    '{1'b0, 2'd2, 2'd0, 10'h200, 32'h0, 1'b0, 32'h11111111, 4'd8},
    '{1'b1, 2'd2, 2'd2, 10'h200, 32'h0, 1'b0, 32'h0, 4'd9},         // R9 pair 1
    '{1'b0, 2'd2, 2'd0, 10'h200, 32'h0, 1'b0, 32'hFFFFFFFF, 4'd9},
    '{1'b0, 2'd2, 2'd0, 10'h3FC, 32'h0, 1'b0, 32'hFFFFFFFF, 4'd9},
    '{1'b0, 2'd2, 2'd0, 10'h080, 32'h0, 1'b0, 32'h00000000, 4'd9},
    '{1'b1, 2'd2, 2'd2, 10'h000, 32'h0, 1'b0, 32'h0, 4'd9},         // R9 pair 0
    '{1'b0, 2'd2, 2'd0, 10'h080, 32'h0, 1'b0, 32'hFFFFFFFF, 4'd9},
    '{1'b0, 2'd3, 2'd0, 10'h000, 32'h0, 1'b1, 32'h0, 4'd5}          // R5 size 3
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one transfer; returns response cycle count, err and data
  task automatic xfer(input logic w, input logic [1:0] sz, input logic [1:0] cm,
                      input logic [AW-1:0] ad, input logic [31:0] wd, input bit wait_idle,
                      output int lat, output logic e, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; size = sz; op = cm; addr = ad; wdata = wd;
    @(negedge clk);
    req = 1'b0;
    lat = 1;
    while (!rdy && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    e = err;
    d = rdata;
    if (wait_idle) while (busy) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin : main
    int lat;
    logic e;
    logic [31:0] d;
    int n;

    repeat (3) @(negedge clk);
    check(rdy == 1'b0 && err == 1'b0 && busy == 1'b0, "R1 reset outputs",
          {29'd0, rdy, err, busy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rdy == 1'b0 && err == 1'b0 && busy == 1'b0, "R1 after reset",
          {29'd0, rdy, err, busy}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      xfer(VECS[i].w, VECS[i].sz, VECS[i].cm, VECS[i].ad, VECS[i].wd, 1'b1, lat, e, d);
      check(e == VECS[i].xerr, $sformatf("R%0d vec%0d err", VECS[i].rq, i),
            {31'd0, e}, {31'd0, VECS[i].xerr});
      check(d == VECS[i].xd, $sformatf("R%0d vec%0d data", VECS[i].rq, i), d, VECS[i].xd);
      // R3 reads take two cycles, all other responses one
      check(lat == ((!VECS[i].w && !VECS[i].xerr) ? 2 : 1),
            $sformatf("R3 vec%0d latency", i), lat,
            (!VECS[i].w && !VECS[i].xerr) ? 32'd2 : 32'd1);
    end

    // R10: requests during busy are refused and change nothing
    xfer(1'b1, 2'd2, 2'd0, 10'h010, 32'h0000FFFF, 1'b0, lat, e, d);
    check(!e && busy, "R10 busy after program", {30'd0, e, busy}, 32'd1);
    xfer(1'b0, 2'd2, 2'd0, 10'h010, 32'h0, 1'b0, lat, e, d);
    check(e && lat == 1 && d == 32'h0, "R10 read in busy refused", {31'd0, e}, 32'd1);
    xfer(1'b1, 2'd2, 2'd0, 10'h010, 32'h00000000, 1'b0, lat, e, d);
    check(e == 1'b1, "R10 command in busy refused", {31'd0, e}, 32'd1);
    check(rdy == 1'b1 && err == 1'b1, "R11 err with rdy", {30'd0, rdy, err}, 32'd3);
    while (busy) @(negedge clk);
    xfer(1'b0, 2'd2, 2'd0, 10'h010, 32'h0, 1'b1, lat, e, d);
    check(!e && d == 32'h0000FFFF, "R10 refused program left data", d, 32'h0000FFFF);

    // R10: busy window length
    xfer(1'b1, 2'd2, 2'd0, 10'h018, 32'hFFFF0000, 1'b0, lat, e, d);
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    check(n == BUSY_CYC, "R10 busy length", n, BUSY_CYC);
    xfer(1'b0, 2'd2, 2'd0, 10'h018, 32'h0, 1'b1, lat, e, d);
    check(!e && d == 32'hFFFF0000 && lat == 2, "R3 read right after busy", d, 32'hFFFF0000);

    // R5: byte at odd offset is fine, word at offset 3 is not
    xfer(1'b0, 2'd1, 2'd0, 10'h003, 32'h0, 1'b1, lat, e, d);
    check(e && d == 32'h0, "R5 word offset 3", {31'd0, e}, 32'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule